// File: doc/BRIEF.md
# Drive select and strobe sequencer

This block drives the address lines of a floppy drive: three phase lines, a separate select line and a latch strobe. It performs one of two accesses on request. A command presents a 4-bit code to the drive and then pulses the strobe so the drive latches the command. A sense read presents a 4-bit code, waits for the drive's shared sense line to settle, and captures that line. The low three bits of a code go on the phase lines. Bit 3 goes on the select line.

Each access begins by parking the phase lines at the relax code (3) for a fixed time. The block then moves to the requested code. Setup time, strobe width, hold time and settle time are parameters counted in clock cycles. The sense line is active-low and passes through a synchroniser before it is captured. While an access runs, busy is high and new requests are ignored. A one-cycle done pulse marks the end of every access. For a sense read, the captured bit is valid from that pulse onward.

Top module: `fdd_line_seq`

## Requirements
- R1: After reset and between accesses, the lines rest at the relax code: ca_out = 3, sel_out = 0, strobe_out = 0, busy = 0 and done = 0. After reset, sense_bit is 0.
- R2: A request is accepted at a clock edge where req = 1 and busy = 0. For the next PARK_CYC cycles, ca_out = 3, sel_out = req_code[3], strobe_out = 0 and busy = 1.
- R3: After the park phase, ca_out = code[2:0] and sel_out = code[3]. Both hold steady until the access ends.
- R4: For a command (req_cmd = 1), the code is presented for SETUP_CYC cycles with strobe_out low. strobe_out is then high for exactly STROBE_CYC cycles. It is then low for HOLD_CYC further cycles, with the code still presented.
- R5: For a sense read (req_cmd = 0), strobe_out stays low throughout. The code is presented for SETTLE_CYC cycles.
- R6: The sense line is active-low. sense_bit becomes 1 when the synchronised sense_n captured at the end of the settle phase is 0, and becomes 0 when it is 1.
- R7: busy is high for PARK_CYC+SETUP_CYC+STROBE_CYC+HOLD_CYC cycles for a command, and for PARK_CYC+SETTLE_CYC cycles for a sense read. done is high for exactly one cycle, the first cycle in which busy is low again.
- R8: A request made while busy = 1 is ignored. The running access keeps its code and its timing.
- R9: sense_bit holds its value until the next sense read completes. A command does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start an access (accepted only while idle) |
| req_cmd | input | 1 | 1 = command with strobe, 0 = sense read |
| req_code | input | 4 | Code to present; bit 3 goes to sel_out |
| sense_n | input | 1 | Drive sense line, active-low |
| busy | output | 1 | High while an access is in progress |
| done | output | 1 | One-cycle pulse at the end of an access |
| sense_bit | output | 1 | Last captured sense value, active-high |
| ca_out | output | 3 | Phase lines |
| sel_out | output | 1 | Select line (code bit 3) |
| strobe_out | output | 1 | Latch strobe |

## Verification
Counting from the clock edge that accepts a request, each result is due at a fixed cycle:
- the park phase occupies cycles 1 to P;
- the code alone occupies the next S cycles (command) or T cycles (sense read);
- the strobe occupies the W cycles after that, and the hold phase the final H cycles;
- done and the new sense_bit appear in cycle N+1, where N is the busy length.

The bench drives inputs on falling edges and counts cycles from the accepting edge. On each falling edge it compares every output with the value expected for that cycle index. It sweeps all 16 codes in both modes, with both sense levels. In half of the runs it also issues an extra request in the middle of the access, to confirm that the request is ignored.

// File: rtl/fdd_line_pkg.sv
package fdd_line_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_PARK    = 3'd1,
      ST_PRESENT = 3'd2,
      ST_STROBE  = 3'd3,
      ST_HOLD    = 3'd4
   } seq_state_t;

   localparam logic [3:0] CODE_RELAX      = 4'd3;
   localparam logic [3:0] CODE_STEP_UP    = 4'd0;
   localparam logic [3:0] CODE_STEP_DOWN  = 4'd4;
   localparam logic [3:0] CODE_RDATA_H0   = 4'd4;
   localparam logic [3:0] CODE_RDATA_H1   = 4'd12;
   localparam logic [3:0] CODE_TRACK0     = 4'd10;
   localparam logic [3:0] CODE_SEEK_OK    = 4'd14;
   localparam logic [3:0] CODE_PRESENT    = 4'd7;

   function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fdd_phase_timer.sv
module fdd_phase_timer #(
   parameter int unsigned CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   AST_TIMER_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1)); // R7

endmodule

// File: rtl/fdd_sense_capture.sv
module fdd_sense_capture #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_n,
   input  logic capture,
   output logic bit_o
);

   logic synced_n;

   generate
      if (STAGES == 0) begin : g_direct
         assign synced_n = line_n;
      end else if (STAGES == 1) begin : g_one
         logic stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= 1'b1;
            else        stage_q <= line_n;
         end
         assign synced_n = stage_q;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], line_n};
         end
         assign synced_n = chain_q[STAGES-1];
      end
   endgenerate

   logic bit_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bit_q <= 1'b0;
      else if (capture) bit_q <= ~synced_n;
   end
   assign bit_o = bit_q;

   AST_BIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(capture) |-> $stable(bit_o)); // R9

endmodule

// File: rtl/fdd_line_seq.sv
module fdd_line_seq
   import fdd_line_pkg::*;
#(
   parameter int unsigned PARK_CYC    = 4,
   parameter int unsigned SETUP_CYC   = 8,
   parameter int unsigned STROBE_CYC  = 8,
   parameter int unsigned HOLD_CYC    = 4,
   parameter int unsigned SETTLE_CYC  = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req,
   input  logic       req_cmd,
   input  logic [3:0] req_code,
   input  logic       sense_n,
   output logic       busy,
   output logic       done,
   output logic       sense_bit,
   output logic [2:0] ca_out,
   output logic       sel_out,
   output logic       strobe_out
);

   localparam int unsigned MAX_CYC = max_of(max_of(PARK_CYC, SETUP_CYC),
                                            max_of(max_of(STROBE_CYC, HOLD_CYC), SETTLE_CYC));
   localparam int unsigned CW = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
   localparam logic [CW-1:0] LD_PARK   = CW'(PARK_CYC - 1);
   localparam logic [CW-1:0] LD_SETUP  = CW'(SETUP_CYC - 1);
   localparam logic [CW-1:0] LD_STROBE = CW'(STROBE_CYC - 1);
   localparam logic [CW-1:0] LD_HOLD   = CW'(HOLD_CYC - 1);
   localparam logic [CW-1:0] LD_SETTLE = CW'(SETTLE_CYC - 1);

   generate
      if (PARK_CYC < 1 || SETUP_CYC < 1 || STROBE_CYC < 1 || HOLD_CYC < 1 || SETTLE_CYC < 1) begin : g_bad_phase
         $error("fdd_line_seq: every phase needs at least one cycle");
      end
      if (PARK_CYC + SETTLE_CYC <= SYNC_STAGES) begin : g_bad_sync
         $error("fdd_line_seq: park plus settle must exceed the synchroniser depth");
      end
   endgenerate

   seq_state_t    state_q, state_d;
   logic [3:0]    code_q;
   logic          cmd_q;
   logic          done_q;
   logic          expired;
   logic          load;
   logic [CW-1:0] load_val;
   logic          finish;
   logic          capture;

   always_comb begin
      state_d  = state_q;
      load     = 1'b0;
      load_val = LD_PARK;
      finish   = 1'b0;
      unique case (state_q)
         ST_IDLE: if (req) begin
            state_d = ST_PARK;
            load    = 1'b1;
         end
         ST_PARK: if (expired) begin
            state_d  = ST_PRESENT;
            load     = 1'b1;
            load_val = cmd_q ? LD_SETUP : LD_SETTLE;
         end
         ST_PRESENT: if (expired) begin
            if (cmd_q) begin
               state_d  = ST_STROBE;
               load     = 1'b1;
               load_val = LD_STROBE;
            end else begin
               state_d = ST_IDLE;
               finish  = 1'b1;
            end
         end
         ST_STROBE: if (expired) begin
            state_d  = ST_HOLD;
            load     = 1'b1;
            load_val = LD_HOLD;
         end
         ST_HOLD: if (expired) begin
            state_d = ST_IDLE;
            finish  = 1'b1;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   assign capture = finish && !cmd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         code_q  <= CODE_RELAX;
         cmd_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= finish;
         if (state_q == ST_IDLE && req) begin
            code_q <= req_code;
            cmd_q  <= req_cmd;
         end
      end
   end

   fdd_phase_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .expired  (expired)
   );

   fdd_sense_capture #(.STAGES(SYNC_STAGES)) u_sense (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_n  (sense_n),
      .capture (capture),
      .bit_o   (sense_bit)
   );

   logic parked;
   assign parked     = (state_q == ST_IDLE) || (state_q == ST_PARK);
   assign ca_out     = parked ? CODE_RELAX[2:0] : code_q[2:0];
   assign sel_out    = (state_q == ST_IDLE) ? CODE_RELAX[3] : code_q[3];
   assign strobe_out = (state_q == ST_STROBE);
   assign busy       = (state_q != ST_IDLE);
   assign done       = done_q;

   AST_IDLE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (ca_out == 3'd3 && !sel_out && !strobe_out)); // R1
   AST_ACCEPT_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req) |=> (busy && ca_out == 3'd3 && !strobe_out)); // R2
   AST_CODE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && $past(state_q) != ST_PARK) |-> ($stable(ca_out) && $stable(sel_out))); // R3
   AST_STROBE_CMD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_out |-> (busy && cmd_q)); // R5
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy))); // R7
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_BUSY_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(code_q) && $stable(cmd_q))); // R8

endmodule

// File: tb/fdd_line_seq_test.sv
module fdd_line_seq_test;

   localparam int CLK_PERIOD = 10;
   localparam int P = 2, S = 3, W = 2, H = 1, T = 4, SY = 2;
   localparam int N_CMD = P + S + W + H;
   localparam int N_SNS = P + T;
   localparam int WATCHDOG = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req = 1'b0;
   logic       req_cmd = 1'b0;
   logic [3:0] req_code = 4'd0;
   logic       sense_n = 1'b1;
   logic       busy, done, sense_bit, sel_out, strobe_out;
   logic [2:0] ca_out;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   logic exp_sense = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fdd_line_seq #(
      .PARK_CYC(P), .SETUP_CYC(S), .STROBE_CYC(W), .HOLD_CYC(H),
      .SETTLE_CYC(T), .SYNC_STAGES(SY)
   ) uut (
      .clk(clk), .rst_n(rst_n), .req(req), .req_cmd(req_cmd), .req_code(req_code),
      .sense_n(sense_n), .busy(busy), .done(done), .sense_bit(sense_bit),
      .ca_out(ca_out), .sel_out(sel_out), .strobe_out(strobe_out)
   );

   // packed observation: busy, done, strobe, sel, ca[2:0], sense_bit
   task automatic check_lines(input string tag, input logic [7:0] expv);
      logic [7:0] act;
      act = {busy, done, strobe_out, sel_out, ca_out, sense_bit};
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: got busy,done,strb,sel,ca,sense=%b expected %b", tag, act, expv);
      end
   endtask

   task automatic run_access(input logic cmd, input logic [3:0] code, input logic sn, input bit poke);
      int n;
      logic [7:0] e;
      string tag;
      n = cmd ? N_CMD : N_SNS;
      @(negedge clk);
      sense_n  = sn;
      repeat (SY + 1) @(negedge clk);
      req = 1'b1; req_cmd = cmd; req_code = code;
      @(negedge clk);
      req = 1'b0;
      for (int i = 1; i <= n + 2; i++) begin
         if (i <= P) begin
            e = {1'b1, 1'b0, 1'b0, code[3], 3'd3, exp_sense};
            tag = "R2 park";
         end else if (i <= n) begin
            logic stb;
            stb = cmd && (i > P + S) && (i <= P + S + W);
            e = {1'b1, 1'b0, stb, code[3], code[2:0], exp_sense};
            tag = cmd ? (stb ? "R4 strobe" : "R3/R4 present") : "R5 settle";
            if (poke) tag = {tag, " R8"};
         end else if (i == n + 1) begin
            if (!cmd) exp_sense = ~sn;
            e = {1'b0, 1'b1, 1'b0, 1'b0, 3'd3, exp_sense};
            tag = cmd ? "R7 done R9 unchanged" : "R6 R7 done";
         end else begin
            e = {1'b0, 1'b0, 1'b0, 1'b0, 3'd3, exp_sense};
            tag = "R1 R7 back idle";
         end
         check_lines(tag, e);
         if (poke && i == 3) begin
            req = 1'b1; req_cmd = ~cmd; req_code = ~code;
         end else begin
            req = 1'b0;
         end
         @(negedge clk);
      end
      req = 1'b0;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: run did not complete, got hang expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check_lines("R1 in reset", {1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 1'b0});
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_lines("R1 after reset", {1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 1'b0});
      for (int c = 0; c < 16; c++) begin
         for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 2; s++) begin
               run_access(m[0], c[3:0], s[0], (c % 2) == 1);
            end
         end
      end
      // sense readback across a command: R9
      run_access(1'b0, 4'd10, 1'b0, 1'b0);
      run_access(1'b1, 4'd4, 1'b1, 1'b0);
      check_lines("R9 sense kept after command", {1'b0, 1'b0, 1'b0, 1'b0, 3'd3, 1'b1});
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule